// File: doc/BRIEF.md
# Synthesizer Channel and Calibration Sequencer

This block is the digital sequencer that sits beside a fractional-N frequency synthesizer in a 2.4 GHz IEEE 802.15.4 radio. It holds the selected channel number, turns it into a center frequency in MHz, and steps through the settling intervals that follow an enable, a channel hop, the start of a transmission and the end of one. For each interval it also decides which calibration loops are active. These are center-frequency tuning and delay-cell calibration.

The completion of each calibration and settling step is modelled as a fixed number of clock cycles. That number is derived from a cycles-per-microsecond parameter. When a calibration interval finishes, a lock interrupt is pulsed. When a hop begins, an unlock interrupt is pulsed. The two transmit frequency shifts run without any interrupt. A surrounding controller drives the enable level and one-cycle event strobes. It watches `busy`, `ready` and `tx_ok` to know when the frequency may be used.

Top module: `synth_seq`

## Requirements
- R1: After reset the channel is 11, `freq_mhz` is 2405, and `busy`, `ready`, `tx_ok`, `cf_cal`, `dcu_cal`, `irq_lock` and `irq_unlock` are all 0.
- R2: `freq_mhz` always equals 2405 + 5 × (`chan` − 11). Valid channel values on the 5-bit `ch_wdata` field are 11 to 26.
- R3: A channel write with a value below 11 or above 26 is ignored, and the stored channel is kept.
- R4: When `enable` rises from the off state, both `cf_cal` and `dcu_cal` are high and `busy` is high for exactly 110 × CYC_PER_US cycles. After that, `ready` goes high and `irq_lock` pulses.
- R5: While locked, a write of a different valid channel takes the new channel, pulses `irq_unlock`, and raises `cf_cal` only (`dcu_cal` stays 0). `busy` is held for 11 × CYC_PER_US cycles, and then `irq_lock` pulses.
- R6: While locked, a write of the channel already selected starts no calibration and raises no interrupt.
- R7: While locked, `tx_start` holds `busy` for 16 × CYC_PER_US cycles. After that `tx_ok` and `ready` are high. No interrupt is raised.
- R8: While transmitting, `tx_end` holds `busy` for 32 × CYC_PER_US cycles. After that the block is back in the locked state, with `ready` high and `tx_ok` low. No interrupt is raised.
- R9: With `enable` low, the next cycle is in the off state, whatever interval was in progress. `busy` and `ready` are 0 and no interrupt is raised.
- R10: Channel writes during a settling interval or a transmission are ignored. `tx_start` is ignored unless the block is locked. In the locked state, `tx_start` takes priority over a channel write in the same cycle.
- R11: Each interrupt output is high for one cycle only, and `busy` and `ready` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Synthesizer enable level |
| ch_we | input | 1 | Channel write strobe |
| ch_wdata | input | 5 | Channel number to write |
| tx_start | input | 1 | Transmit start strobe |
| tx_end | input | 1 | Transmit end strobe |
| chan | output | 5 | Selected channel |
| freq_mhz | output | 12 | Center frequency in MHz |
| busy | output | 1 | A settling interval is running |
| ready | output | 1 | The synthesizer is locked |
| tx_ok | output | 1 | Locked on the transmit frequency |
| cf_cal | output | 1 | Center-frequency tuning is active |
| dcu_cal | output | 1 | Delay-cell calibration is active |
| irq_lock | output | 1 | Lock interrupt pulse |
| irq_unlock | output | 1 | Unlock interrupt pulse |

## Verification
Every output except `freq_mhz` is registered. An event sampled at one clock edge is therefore visible just after that edge: `busy` rises, and for a hop `irq_unlock` pulses. `busy` then stays high for exactly the interval length in cycles. `ready` and `irq_lock` appear just after the edge that ends the interval, and `irq_lock` clears one cycle later. The bench drives and samples on falling edges. It counts the falling edges at which `busy` is high and compares that count with the interval length. It reads the interrupt and status outputs at the first falling edge after the interval ends, and again one edge later.

// File: rtl/synth_seq.sv
module synth_seq #(
  parameter int CYC_PER_US = 16,
  parameter int EN_US      = 110,
  parameter int HOP_US     = 11,
  parameter int TXUP_US    = 16,
  parameter int TXDN_US    = 32,
  parameter int CH_MIN     = 11,
  parameter int CH_MAX     = 26,
  parameter int F_BASE     = 2405,
  parameter int F_STEP     = 5
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        enable,
  input  logic        ch_we,
  input  logic [4:0]  ch_wdata,
  input  logic        tx_start,
  input  logic        tx_end,
  output logic [4:0]  chan,
  output logic [11:0] freq_mhz,
  output logic        busy,
  output logic        ready,
  output logic        tx_ok,
  output logic        cf_cal,
  output logic        dcu_cal,
  output logic        irq_lock,
  output logic        irq_unlock
);
  localparam int EN_CYC   = CYC_PER_US * EN_US;
  localparam int HOP_CYC  = CYC_PER_US * HOP_US;
  localparam int TXUP_CYC = CYC_PER_US * TXUP_US;
  localparam int TXDN_CYC = CYC_PER_US * TXDN_US;
  localparam int MAX_A    = (EN_CYC > TXDN_CYC) ? EN_CYC : TXDN_CYC;
  localparam int MAX_B    = (HOP_CYC > TXUP_CYC) ? HOP_CYC : TXUP_CYC;
  localparam int MAX_CYC  = (MAX_A > MAX_B) ? MAX_A : MAX_B;
  localparam int CW       = $clog2(MAX_CYC + 1);
  localparam logic [4:0] LO = 5'(CH_MIN);
  localparam logic [4:0] HI = 5'(CH_MAX);

  typedef enum logic [2:0] {
    S_OFF, S_SETTLE, S_LOCK, S_HOP, S_TXUP, S_TXON, S_TXDN
  } st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic [4:0]    chan_q;
  logic          irq_l, irq_u;

  wire wr_ok = ch_we && (ch_wdata >= LO) && (ch_wdata <= HI);
  wire done  = (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= S_OFF;
      cnt    <= '0;
      chan_q <= LO;
      irq_l  <= 1'b0;
      irq_u  <= 1'b0;
    end else begin
      irq_l <= 1'b0;
      irq_u <= 1'b0;
      if (!done) cnt <= cnt - 1'b1;
      if (!enable) begin
        st  <= S_OFF;
        cnt <= '0;
        if (wr_ok) chan_q <= ch_wdata;
      end else begin
        case (st)
          S_OFF: begin
            if (wr_ok) chan_q <= ch_wdata;
            st  <= S_SETTLE;
            cnt <= CW'(EN_CYC - 1);
          end
          S_SETTLE: if (done) begin st <= S_LOCK; irq_l <= 1'b1; end
          S_LOCK: begin
            if (tx_start) begin
              st  <= S_TXUP;
              cnt <= CW'(TXUP_CYC - 1);
            end else if (wr_ok && ch_wdata != chan_q) begin
              chan_q <= ch_wdata;
              st     <= S_HOP;
              cnt    <= CW'(HOP_CYC - 1);
              irq_u  <= 1'b1;
            end
          end
          S_HOP:  if (done) begin st <= S_LOCK; irq_l <= 1'b1; end
          S_TXUP: if (done) st <= S_TXON;
          S_TXON: if (tx_end) begin st <= S_TXDN; cnt <= CW'(TXDN_CYC - 1); end
          S_TXDN: if (done) st <= S_LOCK;
          default: st <= S_OFF;
        endcase
      end
    end
  end

  assign chan       = chan_q;
  assign freq_mhz   = 12'(F_BASE + F_STEP * (int'(chan_q) - CH_MIN));
  assign busy       = (st == S_SETTLE) || (st == S_HOP) || (st == S_TXUP) || (st == S_TXDN);
  assign ready      = (st == S_LOCK) || (st == S_TXON);
  assign tx_ok      = (st == S_TXON);
  assign cf_cal     = (st == S_SETTLE) || (st == S_HOP);
  assign dcu_cal    = (st == S_SETTLE);
  assign irq_lock   = irq_l;
  assign irq_unlock = irq_u;

  assert_freq_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (freq_mhz >= 12'(F_BASE)) && (freq_mhz <= 12'(F_BASE + F_STEP * (CH_MAX - CH_MIN))));
  assert_lock_after_cal_R4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_lock |-> $past(cf_cal));
  assert_no_irq_tx_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ok || (busy && !cf_cal)) |-> (!irq_lock && !irq_unlock));
  assert_quiet_return_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy) && !$past(cf_cal) && ready && !tx_ok) |-> !irq_lock);
  assert_abort_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!busy && !ready && !irq_lock && !irq_unlock));
  assert_lock_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    irq_lock |=> !irq_lock);
  assert_unlock_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    irq_unlock |=> !irq_unlock);
  assert_busy_ready_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && ready));
endmodule

// File: tb/synth_seq_test.sv
module synth_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int CPU = 16;
  localparam int EN_N = 110 * CPU, HOP_N = 11 * CPU, UP_N = 16 * CPU, DN_N = 32 * CPU;
  localparam int NV = 8;
  localparam logic [4:0] WR_V  [NV] = '{5'd26, 5'd27, 5'd15, 5'd0, 5'd11, 5'd10, 5'd20, 5'd31};
  localparam logic [4:0] EXP_V [NV] = '{5'd26, 5'd26, 5'd15, 5'd15, 5'd11, 5'd11, 5'd20, 5'd20};

  logic clk = 0, rst_n = 0, enable = 0, ch_we = 0, tx_start = 0, tx_end = 0;
  logic [4:0] ch_wdata = '0;
  logic [4:0] chan;
  logic [11:0] freq_mhz;
  logic busy, ready, tx_ok, cf_cal, dcu_cal, irq_lock, irq_unlock;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  synth_seq #(.CYC_PER_US(CPU)) uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .ch_we(ch_we), .ch_wdata(ch_wdata),
    .tx_start(tx_start), .tx_end(tx_end), .chan(chan), .freq_mhz(freq_mhz),
    .busy(busy), .ready(ready), .tx_ok(tx_ok), .cf_cal(cf_cal), .dcu_cal(dcu_cal),
    .irq_lock(irq_lock), .irq_unlock(irq_unlock));

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] d);
    ch_wdata = d; ch_we = 1;
    @(negedge clk);
    ch_we = 0;
  endtask

  task automatic measure(output int n, output int nl, output int nu);
    n = 0; nl = 0; nu = 0;
    while (busy && n < 4000) begin
      n++; nl += int'(irq_lock); nu += int'(irq_unlock);
      @(negedge clk);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=expired expected=done");
    finish_run();
  end

  initial begin
    int n, nl, nu;
    repeat (3) @(negedge clk);
    chk("R1 chan", chan, 11);
    chk("R1 freq", freq_mhz, 2405);
    chk("R1 flags", {busy, ready, tx_ok, cf_cal, dcu_cal, irq_lock, irq_unlock}, 0);
    rst_n = 1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      wr(WR_V[i]);
      chk("R3 table chan", chan, EXP_V[i]);
      chk("R2 table freq", freq_mhz, 2405 + 5 * (int'(EXP_V[i]) - 11));
    end

    enable = 1;
    @(negedge clk);
    chk("R4 both cals", {cf_cal, dcu_cal}, 2'b11);
    measure(n, nl, nu);
    chk("R4 enable settle cycles", n, EN_N);
    chk("R4 irqs during settle", nl + nu, 0);
    chk("R4 lock pulse", irq_lock, 1);
    chk("R4 ready", ready, 1);
    @(negedge clk);
    chk("R11 lock pulse ends", irq_lock, 0);

    wr(5'd22);
    chk("R5 unlock pulse", irq_unlock, 1);
    chk("R5 cf only", {cf_cal, dcu_cal}, 2'b10);
    measure(n, nl, nu);
    chk("R5 hop cycles", n, HOP_N);
    chk("R5 lock after hop", irq_lock, 1);
    chk("R5 unlock count", nu, 1);
    chk("R2 hop freq", freq_mhz, 2460);
    @(negedge clk);
    chk("R11 unlock low", irq_unlock, 0);

    wr(5'd22);
    chk("R6 same channel no cal", {busy, cf_cal, irq_unlock, ready}, 4'b0001);
    wr(5'd5);
    chk("R3 invalid while locked", chan, 22);

    tx_start = 1; @(negedge clk); tx_start = 0;
    measure(n, nl, nu);
    chk("R7 tx shift cycles", n, UP_N);
    chk("R7 no irq", nl + nu + irq_lock + irq_unlock, 0);
    chk("R7 tx_ok", {tx_ok, ready}, 2'b11);
    wr(5'd12);
    chk("R10 write during tx ignored", chan, 22);
    tx_start = 1; @(negedge clk); tx_start = 0;
    chk("R10 tx_start ignored in tx", busy, 0);

    tx_end = 1; @(negedge clk); tx_end = 0;
    measure(n, nl, nu);
    chk("R8 return cycles", n, DN_N);
    chk("R8 no irq", nl + nu + irq_lock + irq_unlock, 0);
    chk("R8 locked rx", {ready, tx_ok}, 2'b10);

    ch_wdata = 5'd13; ch_we = 1; tx_start = 1;
    @(negedge clk);
    ch_we = 0; tx_start = 0;
    chk("R10 tx priority chan", chan, 22);
    chk("R10 tx priority no cal", cf_cal, 0);
    measure(n, nl, nu);
    tx_end = 1; @(negedge clk); tx_end = 0;
    measure(n, nl, nu);

    wr(5'd12);
    repeat (50) @(negedge clk);
    enable = 0;
    nl = 0; nu = 0;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      nl += int'(irq_lock) + int'(busy) + int'(ready);
      nu += int'(irq_unlock);
    end
    chk("R9 abort quiet", nl + nu, 0);
    chk("R9 chan kept", chan, 12);
    tx_start = 1; @(negedge clk); tx_start = 0;
    chk("R10 tx_start ignored off", busy, 0);

    enable = 1;
    @(negedge clk);
    wr(5'd14);
    chk("R10 write during settle ignored", chan, 12);
    measure(n, nl, nu);
    chk("R4 re-enable cycles", n, EN_N - 1);
    chk("R4 re-lock", irq_lock, 1);
    finish_run();
  end
endmodule